// File: doc/BRIEF.md
# Single-Pulse PWM Gate Logic

This block turns digital comparator results into one active-high gate-drive pulse per switching period. An oscillator delivers a short clock pulse at the start of every period. The drive pulse can start only after that clock pulse has ended. It then lasts until a stop condition ends it. Three stop flags can end the pulse: a ramp-crossing flag from the PWM comparator, a pulse-by-pulse current-limit flag and a fault-hold flag. All three feed a termination latch, and each clock pulse clears that latch.

A toggle stage flips at the end of every clock pulse. Only every other period is allowed to carry a pulse, so the duty cycle can never exceed 50%. An enable line holds the output off while it is low, for example during slow start. All inputs are synchronous single-bit flags sampled on the system clock. The drive output is registered, so it reacts on the clock edge that samples the inputs.

Top module: `single_pulse_pwm`

## Requirements
- R1: While rst_ni is low, drive_o is 0. After reset is released, the first period that begins after a clock pulse ends is an active period.
- R2: In an active period, drive_o goes to 1 on the edge that samples osc_pulse_i low after it was high, provided enable_i is 1 and no stop flag is 1 on that edge. drive_o then stays at 1 until a stop condition occurs.
- R3: A 1 on ramp_cross_i ends the pulse: drive_o is 0 after that edge and stays 0 for the rest of the period, even after the flag returns to 0.
- R4: A 1 on ilim_i ends the pulse in the same way as R3.
- R5: A 1 on fault_hold_i ends the pulse in the same way as R3.
- R6: The next clock pulse clears the termination latch, so the next active period carries a fresh pulse.
- R7: Active periods alternate with idle periods. drive_o is never 1 in two consecutive periods and rises at most once per period.
- R8: On any edge where osc_pulse_i is 1, drive_o becomes 0.
- R9: A stop flag that is 1 on the edge where the clock pulse ends suppresses the whole pulse for that period.
- R10: enable_i at 0 makes drive_o 0 on that edge. If enable_i returns to 1 later in the same period, the pulse does not restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| osc_pulse_i | input | 1 | Oscillator clock pulse, high at the start of each period |
| ramp_cross_i | input | 1 | PWM comparator flag: ramp crossed its limit |
| ilim_i | input | 1 | Pulse-by-pulse current-limit flag |
| fault_hold_i | input | 1 | Fault-hold flag from the error latch |
| enable_i | input | 1 | 1 allows pulses; 0 holds the output off |
| drive_o | output | 1 | Gate drive, 1 = on |

## Verification
The bench aims at the edge where the clock pulse ends:
- It raises a stop flag on that exact edge. A design that gives the pulse start priority there would emit a short pulse in a period that should have none.
- It pulses each stop flag for one cycle and then releases it. A design without the latch would restart the drive within the same period.

The bench also removes and restores enable in the middle of a period. This exposes a design that restarts the drive when enable returns.

The bench runs back-to-back periods of random length and width. A toggle that flips on the clock level instead of its falling edge, or that is never used, shows up as pulses in adjacent periods.

// File: rtl/spwm_pkg.sv
package spwm_pkg;
  localparam int unsigned N_STOP    = 3;
  localparam int unsigned STOP_RAMP = 0;
  localparam int unsigned STOP_ILIM = 1;
  localparam int unsigned STOP_FLT  = 2;
  typedef logic [N_STOP-1:0] stop_vec_t;
endpackage

// File: rtl/spwm_phase_toggle.sv
module spwm_phase_toggle (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic osc_i,
  output logic fall_o,
  output logic active_o
);
  logic osc_q, tog_q;

  assign fall_o   = osc_q & ~osc_i;
  // period that starts at this fall is active when toggle is about to set
  assign active_o = ~tog_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      osc_q <= 1'b0;
      tog_q <= 1'b0;
    end else begin
      osc_q <= osc_i;
      if (fall_o) tog_q <= ~tog_q;
    end
  end
endmodule

// File: rtl/spwm_term_latch.sv
module spwm_term_latch #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         osc_i,
  input  logic [N-1:0] set_i,
  output logic         any_set_o,
  output logic         term_o
);
  logic [N:0] or_chain;
  logic       term_q;

  assign or_chain[0] = 1'b0;
  for (genvar g = 0; g < N; g++) begin : g_or
    assign or_chain[g+1] = or_chain[g] | set_i[g];
  end
  assign any_set_o = or_chain[N];
  assign term_o    = term_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        term_q <= 1'b0;
    else if (osc_i)     term_q <= 1'b0;
    else if (any_set_o) term_q <= 1'b1;
  end
endmodule

// File: rtl/single_pulse_pwm.sv
module single_pulse_pwm
  import spwm_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic osc_pulse_i,
  input  logic ramp_cross_i,
  input  logic ilim_i,
  input  logic fault_hold_i,
  input  logic enable_i,
  output logic drive_o
);
  stop_vec_t stop_vec;
  logic fall, active, any_stop, term, enable_q_kill, drive_d, drive_q;

  assign stop_vec[STOP_RAMP] = ramp_cross_i;
  assign stop_vec[STOP_ILIM] = ilim_i;
  assign stop_vec[STOP_FLT]  = fault_hold_i;

  spwm_phase_toggle u_phase (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .osc_i   (osc_pulse_i),
    .fall_o  (fall),
    .active_o(active)
  );

  // disable counts as a stop source for the latch so a re-enable cannot restart
  assign enable_q_kill = ~enable_i;

  spwm_term_latch #(.N(N_STOP + 1)) u_term (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .osc_i    (osc_pulse_i),
    .set_i    ({enable_q_kill, stop_vec}),
    .any_set_o(any_stop),
    .term_o   (term)
  );

  always_comb begin
    if (osc_pulse_i || any_stop || term) drive_d = 1'b0;
    else if (fall)                       drive_d = active;
    else                                 drive_d = drive_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) drive_q <= 1'b0;
    else         drive_q <= drive_d;
  end

  assign drive_o = drive_q;
endmodule

// File: rtl/single_pulse_pwm_chk.sv
module single_pulse_pwm_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic osc_pulse_i,
  input logic ramp_cross_i,
  input logic ilim_i,
  input logic fault_hold_i,
  input logic enable_i,
  input logic drive_o
);
  logic osc_d, had_cur, had_prev, fall_c;
  assign fall_c = osc_d & ~osc_pulse_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      osc_d <= 1'b0; had_cur <= 1'b0; had_prev <= 1'b0;
    end else begin
      osc_d <= osc_pulse_i;
      if (fall_c) begin
        had_prev <= had_cur;
        had_cur  <= 1'b0;
      end else if (drive_o) begin
        had_cur <= 1'b1;
      end
    end
  end

  // R8
  osc_forces_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    osc_pulse_i |=> !drive_o);
  // R3
  ramp_ends_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ramp_cross_i |=> !drive_o);
  // R4
  ilim_ends_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ilim_i |=> !drive_o);
  // R5
  fault_ends_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_hold_i |=> !drive_o);
  // R10
  enable_gates_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enable_i |=> !drive_o);
  // R2
  start_at_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(drive_o) |-> ($past(!osc_pulse_i) && $past(osc_d)));
  // R7
  no_adjacent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive_o |-> !had_prev);
endmodule

bind single_pulse_pwm single_pulse_pwm_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .osc_pulse_i(osc_pulse_i),
  .ramp_cross_i(ramp_cross_i), .ilim_i(ilim_i), .fault_hold_i(fault_hold_i),
  .enable_i(enable_i), .drive_o(drive_o)
);

// File: tb/single_pulse_pwm_test.sv
module single_pulse_pwm_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic osc = 1'b0, ramp = 1'b0, ilim = 1'b0, flt = 1'b0, en = 1'b0;
  logic drive;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  // model state
  bit m_osc_prev = 1'b0, m_drive = 1'b0, m_spent = 1'b0;
  int m_period = 0;

  always #4 clk = ~clk;

  single_pulse_pwm uut (
    .clk_i(clk), .rst_ni(rst_n), .osc_pulse_i(osc), .ramp_cross_i(ramp),
    .ilim_i(ilim), .fault_hold_i(flt), .enable_i(en), .drive_o(drive)
  );

  task automatic check(input bit exp, input string tag);
    n_chk++;
    if (drive !== exp) begin
      n_fail++;
      $display("FAIL %s: drive_o=%b expected=%b t=%0t", tag, drive, exp, $time);
    end
  endtask

  // one cycle: inputs applied at negedge, model advanced, checked at next negedge
  task automatic cyc(input bit o, input bit r, input bit il, input bit f, input bit e);
    string tag;
    bit fall, stop;
    osc = o; ramp = r; ilim = il; flt = f; en = e;
    @(posedge clk);
    fall = m_osc_prev && !o;
    stop = r || il || f || !e;
    m_osc_prev = o;
    if (fall) begin m_period++; m_spent = 1'b0; end
    if (o) begin
      m_drive = 1'b0; m_spent = 1'b0; tag = "R8";
    end else if (stop) begin
      m_drive = 1'b0; m_spent = 1'b1;
      tag = fall ? "R9" : r ? "R3" : il ? "R4" : f ? "R5" : "R10";
    end else if (fall) begin
      m_drive = (m_period % 2) == 1;
      tag = m_drive ? ((m_period > 2) ? "R6" : "R2") : "R7";
    end else begin
      m_drive = m_drive && !m_spent;
      tag = m_spent ? "R10" : "R2";
    end
    @(negedge clk);
    check(m_drive, tag);
  endtask

  // one period: w cycles of clock pulse, then len low cycles; stop source src at index k
  task automatic period(input int w, input int len, input int k, input int src,
                        input int dis_at, input int dis_len);
    for (int i = 0; i < w; i++) cyc(1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    for (int i = 0; i < len; i++) begin
      bit e = !(dis_at >= 0 && i >= dis_at && i < dis_at + dis_len);
      cyc(1'b0, (i == k) && src == 0, (i == k) && src == 1, (i == k) && src == 2, e);
    end
  endtask

  initial begin
    #100000000;
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: run hung");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1851));
    @(negedge clk); osc = 1'b1; en = 1'b1;
    repeat (3) @(negedge clk);
    check(1'b0, "R1");
    rst_n = 1'b1;
    // first period after reset: active, full width
    period(2, 8, -1, 0, -1, 0);
    // idle period
    period(2, 8, -1, 0, -1, 0);
    // active, ramp ends it, then latch clears for following active
    period(1, 10, 4, 0, -1, 0);
    period(1, 6, -1, 0, -1, 0);
    period(2, 10, 3, 1, -1, 0);   // ilim
    period(2, 6, -1, 0, -1, 0);
    period(3, 10, 5, 2, -1, 0);   // fault
    period(1, 6, -1, 0, -1, 0);
    period(1, 10, -1, 0, -1, 0);  // R6 fresh pulse
    period(1, 6, -1, 0, -1, 0);
    period(2, 10, 0, 0, -1, 0);   // R9 stop at clock-pulse end
    period(1, 6, -1, 0, -1, 0);
    period(1, 12, -1, 0, 3, 2);   // R10 re-enable mid-period
    period(1, 6, -1, 0, -1, 0);
    period(1, 10, 0, 2, -1, 0);   // R9 with fault
    for (int p = 0; p < 400; p++) begin
      int w = 1 + int'($urandom_range(0, 2));
      int len = 3 + int'($urandom_range(0, 15));
      int k = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, len - 1)) : -1;
      int src = int'($urandom_range(0, 2));
      int d = ($urandom_range(0, 7) == 0) ? int'($urandom_range(0, len - 1)) : -1;
      period(w, len, k, src, d, 1 + int'($urandom_range(0, 2)));
    end
    // reset mid-run restores R1 behaviour
    rst_n = 1'b0;
    @(negedge clk);
    check(1'b0, "R1");
    m_osc_prev = 1'b0; m_drive = 1'b0; m_spent = 1'b0; m_period = 0;
    rst_n = 1'b1;
    period(1, 8, -1, 0, -1, 0);
    period(1, 8, -1, 0, -1, 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule